// File: doc/BRIEF.md
# Sector Lock Protection Unit

This unit holds the volatile software lock state of a flash array built from sixteen 64 KB sectors and decides, for any address a modify command wants to touch, whether that command must be refused. Every sector has a two-bit lock register. The first and the last sector also have one such register for each of their sixteen 4 KB sub-sectors. An active-low top-lock pin protects the whole last sector in hardware, whatever the lock bits say.

Software reaches the registers through a plain address port. `lk_sub` picks the sub-sector register level and `lk_wr` writes the low two bits of `lk_wdata`. The addressed register is always visible on `lk_rdata`. A command decoder places the target address on `chk_addr`, and raises `chk_bulk` for a whole-array erase. It then reads `chk_prot`. These are control and status paths with a single result per cycle, so no valid/ready handshake is used: every input is sampled on every cycle and the outputs cannot be back-pressured.

Top module: `lockprot_unit`

## Requirements
- R1: Addresses are 20 bits. Bits [19:16] select the sector and bits [15:12] select the sub-sector. Sector 0 and sector 15 are the end sectors, and only they have sub-sector registers.
- R2: When `lk_wr` is high at a rising clock edge, the register selected by `lk_addr`/`lk_sub` loads `lk_wdata[1:0]`. Bit 0 is write-lock and bit 1 is lock-down. The new value shows on `lk_rdata` and `chk_prot` from the next cycle.
- R3: While a register's lock-down bit is 1, writes to that register leave both of its bits unchanged until reset.
- R4: An active-low reset (`rst_n`) clears every write-lock and lock-down bit, including the locked-down ones.
- R5: `lk_rdata` follows `lk_addr`/`lk_sub` in the same cycle. Bits [1:0] give the selected register and bits [7:2] always read 0.
- R6: With `lk_sub` = 1 and an address outside the end sectors, `lk_rdata` reads 0 and a write changes no register.
- R7: A sector's write-lock bit set to 1 makes `chk_prot` = 1 for every address in that sector.
- R8: In an end sector, a sub-sector write-lock bit set to 1 protects only the 4 KB range of that sub-sector.
- R9: While `top_lock_n` is low, every address in sector 15 reads as protected. While it is high, it has no effect.
- R10: With `chk_bulk` = 1, `chk_addr` is ignored and `chk_prot` = 1 if any write-lock bit at either level is set or `top_lock_n` is low.
- R11: A lock-down bit alone, with write-lock at 0, does not protect its region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all lock bits |
| lk_addr | input | 20 | Address selecting the lock register |
| lk_sub | input | 1 | 1 selects the sub-sector register level, 0 the sector level |
| lk_wr | input | 1 | Lock register write strobe |
| lk_wdata | input | 8 | Lock write data; bit 0 write-lock, bit 1 lock-down |
| lk_rdata | output | 8 | Selected lock register, zero-extended |
| top_lock_n | input | 1 | Active-low hardware protection of sector 15 |
| chk_addr | input | 20 | Address of the modify command being checked |
| chk_bulk | input | 1 | 1 when the command erases the whole array |
| chk_prot | output | 1 | 1 when the checked command must be refused |

## Verification
Both outputs are combinational, taken from the lock state and the current inputs. A read or a protection query is therefore answered in the cycle its inputs are applied, and a write shows up one cycle after the edge that captures it. The bench changes inputs at the falling edge. It lets the reference model apply the rising edge, and compares both outputs one nanosecond after that edge. At that point a write from the same edge is already due and the combinational paths have settled. Sweeps across every sector and sub-sector register read back the state that each stimulus could have touched.

// File: rtl/lockprot_pkg.sv
package lockprot_pkg;
  // One lock register: write-lock in bit 0, lock-down in bit 1.
  typedef struct packed {
    logic down;
    logic wlock;
  } lock_bits_t;

  localparam int LOCK_BITS = 2;
  localparam int END_SECTORS = 2;
endpackage

// File: rtl/lockprot_cell.sv
module lockprot_cell
  import lockprot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  lock_bits_t wd,
  output lock_bits_t q
);
  // The lock-down bit freezes the whole register until reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we && !q.down) begin
      q <= wd;
    end
  end
endmodule

// File: rtl/lockprot_decode.sv
module lockprot_decode #(
  parameter int SEC_N = 16,
  parameter int SUB_N = 16,
  parameter int SUB_BYTES_W = 12,
  localparam int SEC_W = $clog2(SEC_N),
  localparam int SUBI_W = $clog2(SUB_N),
  localparam int AW = SEC_W + SUBI_W + SUB_BYTES_W
) (
  input  logic [AW-1:0]     addr,
  output logic [SEC_W-1:0]  sec,
  output logic [SUBI_W-1:0] sub,
  output logic              is_end,
  output logic              end_sel
);
  localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(SEC_N - 1);

  always_comb begin
    sec     = addr[AW-1 -: SEC_W];
    sub     = addr[SUB_BYTES_W +: SUBI_W];
    end_sel = (sec == LAST_SEC);
    is_end  = end_sel || (sec == '0);
  end
endmodule

// File: rtl/lockprot_eval.sv
module lockprot_eval #(
  parameter int SEC_N = 16,
  parameter int SUB_N = 16,
  localparam int SEC_W = $clog2(SEC_N),
  localparam int SUBI_W = $clog2(SUB_N),
  localparam int SUBS_TOTAL = lockprot_pkg::END_SECTORS * SUB_N
) (
  input  logic [SEC_N-1:0]      sec_wl,
  input  logic [SUBS_TOTAL-1:0] sub_wl,
  input  logic                  top_lock_n,
  input  logic [SEC_W-1:0]      sec,
  input  logic [SUBI_W-1:0]     sub,
  input  logic                  is_end,
  input  logic                  end_sel,
  input  logic                  bulk,
  output logic                  prot
);
  logic any_lock;
  logic region_lock;

  always_comb begin
    any_lock    = (|sec_wl) || (|sub_wl) || !top_lock_n;
    region_lock = sec_wl[sec]
               || (is_end && sub_wl[{end_sel, sub}])
               || (end_sel && !top_lock_n);
    prot        = bulk ? any_lock : region_lock;
  end
endmodule

// File: rtl/lockprot_unit.sv
module lockprot_unit
  import lockprot_pkg::*;
#(
  parameter int SEC_N = 16,
  parameter int SUB_N = 16,
  parameter int SUB_BYTES_W = 12,
  parameter int DW = 8,
  localparam int SEC_W = $clog2(SEC_N),
  localparam int SUBI_W = $clog2(SUB_N),
  localparam int AW = SEC_W + SUBI_W + SUB_BYTES_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_addr,
  input  logic          lk_sub,
  input  logic          lk_wr,
  input  logic [DW-1:0] lk_wdata,
  output logic [DW-1:0] lk_rdata,
  input  logic          top_lock_n,
  input  logic [AW-1:0] chk_addr,
  input  logic          chk_bulk,
  output logic          chk_prot
);
  localparam int SUBS_TOTAL = END_SECTORS * SUB_N;

  // Register-access side decode
  logic [SEC_W-1:0]  a_sec;
  logic [SUBI_W-1:0] a_sub;
  logic              a_end;
  logic              a_endsel;

  lockprot_decode #(.SEC_N(SEC_N), .SUB_N(SUB_N), .SUB_BYTES_W(SUB_BYTES_W)) i_dec_lk (
    .addr(lk_addr), .sec(a_sec), .sub(a_sub), .is_end(a_end), .end_sel(a_endsel)
  );

  // Query side decode
  logic [SEC_W-1:0]  q_sec;
  logic [SUBI_W-1:0] q_sub;
  logic              q_end;
  logic              q_endsel;

  lockprot_decode #(.SEC_N(SEC_N), .SUB_N(SUB_N), .SUB_BYTES_W(SUB_BYTES_W)) i_dec_chk (
    .addr(chk_addr), .sec(q_sec), .sub(q_sub), .is_end(q_end), .end_sel(q_endsel)
  );

  lock_bits_t wr_bits;
  assign wr_bits = lock_bits_t'(lk_wdata[LOCK_BITS-1:0]);

  lock_bits_t              sec_q [SEC_N];
  lock_bits_t              sub_q [SUBS_TOTAL];
  logic [SEC_N-1:0]        sec_wl;
  logic [SUBS_TOTAL-1:0]   sub_wl;

  // Sector-level registers
  for (genvar i = 0; i < SEC_N; i++) begin : g_sec
    logic we;
    assign we = lk_wr && !lk_sub && (a_sec == SEC_W'(i));
    lockprot_cell i_cell (.clk(clk), .rst_n(rst_n), .we(we), .wd(wr_bits), .q(sec_q[i]));
    assign sec_wl[i] = sec_q[i].wlock;
  end

  // Sub-sector registers, present only in the two end sectors
  for (genvar e = 0; e < END_SECTORS; e++) begin : g_end
    for (genvar j = 0; j < SUB_N; j++) begin : g_sub
      localparam int IDX = e * SUB_N + j;
      logic we;
      assign we = lk_wr && lk_sub && a_end
               && (a_endsel == 1'(e)) && (a_sub == SUBI_W'(j));
      lockprot_cell i_cell (.clk(clk), .rst_n(rst_n), .we(we), .wd(wr_bits), .q(sub_q[IDX]));
      assign sub_wl[IDX] = sub_q[IDX].wlock;
    end
  end

  // Read-back mux
  lock_bits_t rd_bits;
  always_comb begin
    if (!lk_sub) begin
      rd_bits = sec_q[a_sec];
    end else if (a_end) begin
      rd_bits = sub_q[{a_endsel, a_sub}];
    end else begin
      rd_bits = '0;
    end
  end
  assign lk_rdata = {{(DW-LOCK_BITS){1'b0}}, rd_bits};

  lockprot_eval #(.SEC_N(SEC_N), .SUB_N(SUB_N)) i_eval (
    .sec_wl(sec_wl), .sub_wl(sub_wl), .top_lock_n(top_lock_n),
    .sec(q_sec), .sub(q_sub), .is_end(q_end), .end_sel(q_endsel),
    .bulk(chk_bulk), .prot(chk_prot)
  );
endmodule

// File: rtl/lockprot_sva.sv
module lockprot_sva #(
  parameter int SEC_N = 16,
  parameter int SUB_N = 16,
  parameter int SUB_BYTES_W = 12,
  parameter int DW = 8,
  localparam int SEC_W = $clog2(SEC_N),
  localparam int SUBI_W = $clog2(SUB_N),
  localparam int AW = SEC_W + SUBI_W + SUB_BYTES_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] lk_addr,
  input logic          lk_sub,
  input logic          lk_wr,
  input logic [DW-1:0] lk_wdata,
  input logic [DW-1:0] lk_rdata,
  input logic          top_lock_n,
  input logic [AW-1:0] chk_addr,
  input logic          chk_bulk,
  input logic          chk_prot
);
  localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(SEC_N - 1);

  logic [SEC_W-1:0] lk_sec_s;
  logic [SEC_W-1:0] chk_sec_s;
  logic             lk_end_s;
  assign lk_sec_s  = lk_addr[AW-1 -: SEC_W];
  assign chk_sec_s = chk_addr[AW-1 -: SEC_W];
  assign lk_end_s  = (lk_sec_s == '0) || (lk_sec_s == LAST_SEC);

  // R9: pin low protects the whole top sector
  p_pin_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!top_lock_n && !chk_bulk && chk_sec_s == LAST_SEC) |-> chk_prot);

  // R10: bulk query refused while the pin is low
  p_bulk_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_bulk && !top_lock_n) |-> chk_prot);

  // R5: upper read bits are zero
  p_rd_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rdata[DW-1:2] == '0);

  // R6: sub-sector level outside the end sectors reads zero
  p_nonend_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_sub && !lk_end_s) |-> lk_rdata == '0);

  // R3: a locked-down register keeps its value
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rdata[1] |=> (!($stable(lk_addr) && $stable(lk_sub))
                     || lk_rdata[1:0] == $past(lk_rdata[1:0])));

  // R2: a write to an unfrozen register appears the next cycle
  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_wr && !lk_rdata[1] && !(lk_sub && !lk_end_s))
      |=> (!($stable(lk_addr) && $stable(lk_sub))
           || lk_rdata[1:0] == $past(lk_wdata[1:0])));
endmodule

bind lockprot_unit lockprot_sva #(
  .SEC_N(SEC_N), .SUB_N(SUB_N), .SUB_BYTES_W(SUB_BYTES_W), .DW(DW)
) i_sva (
  .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_sub(lk_sub), .lk_wr(lk_wr),
  .lk_wdata(lk_wdata), .lk_rdata(lk_rdata), .top_lock_n(top_lock_n),
  .chk_addr(chk_addr), .chk_bulk(chk_bulk), .chk_prot(chk_prot)
);

// File: tb/test_lockprot_unit.sv
`timescale 1ns/1ps
module test_lockprot_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] lk_addr = '0;
  logic        lk_sub = 1'b0;
  logic        lk_wr = 1'b0;
  logic [7:0]  lk_wdata = '0;
  logic [7:0]  lk_rdata;
  logic        top_lock_n = 1'b1;
  logic [19:0] chk_addr = '0;
  logic        chk_bulk = 1'b0;
  logic        chk_prot;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  int sec_m [16];
  int sub_m [2][16];

  always #2 clk = ~clk;

  lockprot_unit i_lockprot_unit (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_sub(lk_sub), .lk_wr(lk_wr),
    .lk_wdata(lk_wdata), .lk_rdata(lk_rdata), .top_lock_n(top_lock_n),
    .chk_addr(chk_addr), .chk_bulk(chk_bulk), .chk_prot(chk_prot)
  );

  function automatic logic [19:0] mk(input int s, input int j, input int off);
    return 20'((s << 16) | (j << 12) | off);
  endfunction

  function automatic int ref_rd();
    int s = int'(lk_addr) / 65536;
    int j = (int'(lk_addr) / 4096) % 16;
    if (!lk_sub) return sec_m[s];
    if (s == 0) return sub_m[0][j];
    if (s == 15) return sub_m[1][j];
    return 0;
  endfunction

  function automatic int ref_prot();
    int s = int'(chk_addr) / 65536;
    int j = (int'(chk_addr) / 4096) % 16;
    int p = 0;
    if (chk_bulk) begin
      if (!top_lock_n) p = 1;
      for (int k = 0; k < 16; k++) begin
        if (sec_m[k] % 2 == 1) p = 1;
        if (sub_m[0][k] % 2 == 1) p = 1;
        if (sub_m[1][k] % 2 == 1) p = 1;
      end
      return p;
    end
    if (sec_m[s] % 2 == 1) p = 1;
    if (s == 0 && sub_m[0][j] % 2 == 1) p = 1;
    if (s == 15 && (sub_m[1][j] % 2 == 1 || !top_lock_n)) p = 1;
    return p;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 16; k++) begin
      sec_m[k] = 0; sub_m[0][k] = 0; sub_m[1][k] = 0;
    end
  endtask

  task automatic model_edge();
    int s = int'(lk_addr) / 65536;
    int j = (int'(lk_addr) / 4096) % 16;
    int v = int'(lk_wdata) % 4;
    if (!rst_n || !lk_wr) return;
    if (!lk_sub) begin
      if (sec_m[s] < 2) sec_m[s] = v;
    end else if (s == 0) begin
      if (sub_m[0][j] < 2) sub_m[0][j] = v;
    end else if (s == 15) begin
      if (sub_m[1][j] < 2) sub_m[1][j] = v;
    end
  endtask

  task automatic compare(input string req);
    int er = ref_rd();
    int ep = ref_prot();
    checks += 2;
    if (int'(lk_rdata) != er) begin
      errors++;
      $display("FAIL %s lk_rdata addr=%h sub=%0d actual=%h expected=%h",
               req, lk_addr, lk_sub, lk_rdata, er);
    end
    if (int'(chk_prot) != ep) begin
      errors++;
      $display("FAIL %s chk_prot addr=%h bulk=%0d actual=%0d expected=%0d",
               req, chk_addr, chk_bulk, chk_prot, ep);
    end
  endtask

  // Drive at the falling edge, let the model take the rising edge, compare 1 ns later.
  task automatic step(input logic [19:0] a, input logic sb, input logic wr,
                      input logic [7:0] wd, input logic [19:0] ca,
                      input logic bk, input string req);
    @(negedge clk);
    lk_addr = a; lk_sub = sb; lk_wr = wr; lk_wdata = wd; chk_addr = ca; chk_bulk = bk;
    @(posedge clk);
    model_edge();
    #1;
    compare(req);
  endtask

  task automatic wr_lock(input logic [19:0] a, input logic sb, input logic [7:0] wd,
                         input string req);
    step(a, sb, 1'b1, wd, a, 1'b0, req);
    step(a, sb, 1'b0, 8'h00, a, 1'b0, req);
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < 16; s++) begin
      step(mk(s, s, 16'h0), 1'b0, 1'b0, 8'h00, mk(s, 15 - s, 12'h7ff), 1'b0, req);
      step(mk(s, 15 - s, 12'h1), 1'b1, 1'b0, 8'h00, mk(s, s, 12'h0), 1'b0, req);
    end
    for (int j = 0; j < 16; j++) begin
      step(mk(0, j, 12'h0), 1'b1, 1'b0, 8'h00, mk(0, j, 12'hfff), 1'b0, req);
      step(mk(15, j, 12'h0), 1'b1, 1'b0, 8'h00, mk(15, j, 12'h0), 1'b0, req);
    end
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst_n = 1'b0; lk_wr = 1'b0;
    model_clear();
    @(posedge clk);
    #1;
    compare(req);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    model_clear();
    repeat (3) @(posedge clk);
    do_reset("R4");
    sweep("R4 reset state");

    // R7, R2: sector write-lock protects the whole sector only
    wr_lock(mk(3, 5, 12'h10), 1'b0, 8'h01, "R2");
    step(mk(3, 0, 0), 1'b0, 1'b0, 8'h00, mk(3, 15, 12'hfff), 1'b0, "R7");
    step(mk(3, 0, 0), 1'b0, 1'b0, 8'h00, mk(4, 0, 0), 1'b0, "R7 neighbour");
    step(mk(3, 0, 0), 1'b0, 1'b0, 8'h00, mk(2, 15, 12'hfff), 1'b0, "R7 neighbour");
    wr_lock(mk(3, 0, 0), 1'b0, 8'h00, "R2 clear");
    step(mk(3, 0, 0), 1'b0, 1'b0, 8'h00, mk(3, 8, 0), 1'b0, "R2 unlock");

    // R11, R3: lock-down alone does not protect and freezes the register
    wr_lock(mk(5, 0, 0), 1'b0, 8'h02, "R11");
    step(mk(5, 0, 0), 1'b0, 1'b0, 8'h00, mk(5, 3, 0), 1'b0, "R11");
    wr_lock(mk(5, 9, 0), 1'b0, 8'h01, "R3");
    step(mk(5, 0, 0), 1'b0, 1'b0, 8'h00, mk(5, 3, 0), 1'b0, "R3");
    wr_lock(mk(6, 0, 0), 1'b0, 8'h03, "R3");
    wr_lock(mk(6, 0, 0), 1'b0, 8'h00, "R3");
    step(mk(6, 0, 0), 1'b0, 1'b0, 8'h00, mk(6, 1, 0), 1'b0, "R3");

    // R5: upper data bits ignored and read as zero
    wr_lock(mk(9, 0, 0), 1'b0, 8'hfc, "R5");
    wr_lock(mk(10, 0, 0), 1'b0, 8'hfd, "R5");

    // R8, R1: sub-sector locks in the end sectors
    wr_lock(mk(0, 2, 12'habc), 1'b1, 8'h01, "R8");
    step(mk(0, 2, 0), 1'b1, 1'b0, 8'h00, mk(0, 2, 12'h000), 1'b0, "R8");
    step(mk(0, 2, 0), 1'b1, 1'b0, 8'h00, mk(0, 3, 12'h000), 1'b0, "R8 R1");
    step(mk(0, 2, 0), 1'b0, 1'b0, 8'h00, mk(0, 1, 12'hfff), 1'b0, "R8 R1");
    wr_lock(mk(15, 15, 0), 1'b1, 8'h03, "R8");
    wr_lock(mk(15, 15, 0), 1'b1, 8'h00, "R8 R3");
    step(mk(15, 15, 0), 1'b1, 1'b0, 8'h00, mk(15, 15, 12'hfff), 1'b0, "R8");
    step(mk(15, 14, 0), 1'b1, 1'b0, 8'h00, mk(15, 14, 12'hfff), 1'b0, "R8");

    // R6: sub-sector level outside end sectors
    wr_lock(mk(7, 4, 0), 1'b1, 8'h03, "R6");
    step(mk(7, 4, 0), 1'b0, 1'b0, 8'h00, mk(7, 4, 0), 1'b0, "R6");
    sweep("R6 R1 state");

    // R9: hardware pin
    @(negedge clk); top_lock_n = 1'b0;
    step(mk(15, 0, 0), 1'b0, 1'b0, 8'h00, mk(15, 0, 0), 1'b0, "R9");
    step(mk(15, 0, 0), 1'b0, 1'b0, 8'h00, mk(15, 7, 12'h123), 1'b0, "R9");
    step(mk(15, 0, 0), 1'b0, 1'b0, 8'h00, mk(14, 15, 12'hfff), 1'b0, "R9");

    // R10: bulk query
    step(mk(0, 0, 0), 1'b0, 1'b0, 8'h00, mk(8, 0, 0), 1'b1, "R10");
    do_reset("R4");
    step(mk(0, 0, 0), 1'b0, 1'b0, 8'h00, mk(8, 0, 0), 1'b1, "R10 pin");
    @(negedge clk); top_lock_n = 1'b1;
    step(mk(0, 0, 0), 1'b0, 1'b0, 8'h00, mk(15, 0, 0), 1'b1, "R10 clear");
    step(mk(0, 0, 0), 1'b0, 1'b0, 8'h00, mk(15, 0, 0), 1'b0, "R9 released");
    wr_lock(mk(0, 9, 0), 1'b1, 8'h01, "R10 sub");
    step(mk(0, 0, 0), 1'b0, 1'b0, 8'h00, mk(12, 0, 0), 1'b1, "R10 sub");
    wr_lock(mk(0, 9, 0), 1'b1, 8'h00, "R10 sub");
    wr_lock(mk(11, 0, 0), 1'b0, 8'h01, "R10 sec");
    step(mk(0, 0, 0), 1'b0, 1'b0, 8'h00, mk(1, 0, 0), 1'b1, "R10 sec");

    // R4, R3: reset releases lock-down
    wr_lock(mk(2, 0, 0), 1'b0, 8'h03, "R3");
    do_reset("R4");
    sweep("R4 after reset");
    wr_lock(mk(2, 0, 0), 1'b0, 8'h01, "R4 R3 writable");
    step(mk(2, 0, 0), 1'b0, 1'b0, 8'h00, mk(2, 4, 0), 1'b0, "R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule